// File: doc/BRIEF.md
# Dual-Edge Pin Interrupt and Wakeup Detector

This block watches a bank of already-synchronized pin levels and records edges on them. Each pin has four enable bits. Two of them select which edge directions latch a bit in the interrupt status vector. The other two select which directions latch a bit in a separate wake status vector. A pin that must respond to both directions has its bit set in both the rising and the falling enable of the same pair. Only transitions are detected; a steady level never raises anything.

Software sets up the four enables through a small register port. It polls or services the combined interrupt line. It acknowledges pins by writing ones to a clear address, which drops the matching bits in both status vectors. The wake line is meant for a power controller. It responds in the same cycle that a wake-enabled edge appears, and it then stays high until the latched wake bits are acknowledged. Because the wake enables are separate from the interrupt enables, a pin can wake the system without ever raising a normal interrupt.

Top module: `gpio_edge_wake`

## Requirements
- R1: Under reset all four enables and both status vectors become zero, and both output lines are low. The reference level of each pin is loaded from the live input during reset, so a pin that is high when reset ends produces no edge.
- R2: A 0-to-1 change of a pin whose bit is set in the rising interrupt enable (address 0) sets that pin's interrupt status bit on the clock edge that first samples the new level.
- R3: A 1-to-0 change of a pin whose bit is set in the falling interrupt enable (address 1) sets that pin's interrupt status bit in the same way.
- R4: A pin whose bit is set in both the rising and the falling interrupt enables latches status on each of its transitions.
- R5: A transition on a pin whose enable bit for that direction is clear leaves both status vectors and both output lines unchanged.
- R6: A write to the clear address (5) clears each interrupt and wake status bit whose data bit is 1. Bits written as 0 keep their value.
- R7: When an enabled edge and a clear of the same bit fall on the same clock edge, the bit ends up set.
- R8: `irq_out` is high exactly when at least one interrupt status bit is set. It rises in the cycle after the clock edge that latched the bit.
- R9: An edge enabled in the rising wake enable (address 2) or the falling wake enable (address 3) sets that pin's wake status bit. It does not touch interrupt status.
- R10: `wake_req` is high in the same cycle as a wake-enabled edge, before any clock edge. It then stays high while any wake status bit is set.
- R11: Clearing an enable bit stops new status from being latched for that pin. It does not clear a status bit that is already latched.
- R12: Reads return a value one clock after `rd_addr` is sampled. The addresses are: 0 to 3 for the four enables, 4 for interrupt status, 6 for wake status, and 5 (the clear address) and 7, which both read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl | input | NUM_PINS | Synchronized pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | NUM_PINS | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | NUM_PINS | Registered read data |
| irq_out | output | 1 | Combined interrupt line |
| wake_req | output | 1 | Wakeup request line |

## Verification
Edge latching and acknowledgement can both act on one status bit in a single clock. To provoke this, the bench changes a pin level and issues a clear write for that same bit on the same falling edge of the clock. It then reads back the status vector and expects the bit to still be set, while another bit cleared by the same write is gone. The bench also samples the wake line just after it changes a pin and before the next rising edge, to confirm that the wake line responds in the same cycle.

// File: rtl/gpio_ew_pkg.sv
package gpio_ew_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_RISE_IRQ  = 3'd0,
    SEL_FALL_IRQ  = 3'd1,
    SEL_RISE_WAKE = 3'd2,
    SEL_FALL_WAKE = 3'd3,
    SEL_IRQ_STS   = 3'd4,
    SEL_CLEAR     = 3'd5,
    SEL_WAKE_STS  = 3'd6
  } reg_sel_e;

  localparam int NUM_MASKS = 4;
endpackage

// File: rtl/gpio_edge_sense.sv
module gpio_edge_sense #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_lvl,
  output logic [NUM_PINS-1:0] rise_evt,
  output logic [NUM_PINS-1:0] fall_evt
);
  logic [NUM_PINS-1:0] prev_q;

  // Reference level follows the live input, also while in reset,
  // so the first cycle after reset compares equal levels.
  always_ff @(posedge clk) begin
    prev_q <= pin_lvl;
  end

  always_comb begin
    if (rst) begin
      rise_evt = '0;
      fall_evt = '0;
    end else begin
      rise_evt = pin_lvl & ~prev_q;
      fall_evt = ~pin_lvl & prev_q;
    end
  end

  assert_rise_real_R2: assert property (@(posedge clk) disable iff (rst)
    (|rise_evt) |-> ((pin_lvl & ~$past(pin_lvl) & rise_evt) == rise_evt));

  assert_fall_real_R3: assert property (@(posedge clk) disable iff (rst)
    (|fall_evt) |-> ((~pin_lvl & $past(pin_lvl) & fall_evt) == fall_evt));
endmodule

// File: rtl/gpio_ew_cfg.sv
module gpio_ew_cfg
  import gpio_ew_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    wr_addr,
  input  logic [NUM_PINS-1:0] wr_data,
  output logic [NUM_PINS-1:0] rise_irq_m,
  output logic [NUM_PINS-1:0] fall_irq_m,
  output logic [NUM_PINS-1:0] rise_wake_m,
  output logic [NUM_PINS-1:0] fall_wake_m
);
  logic [NUM_PINS-1:0] mask_q [NUM_MASKS];

  for (genvar g = 0; g < NUM_MASKS; g++) begin : g_mask
    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[g] <= '0;
      end else if (wr_en && (wr_addr == SEL_W'(g))) begin
        mask_q[g] <= wr_data;
      end
    end
  end

  assign rise_irq_m  = mask_q[SEL_RISE_IRQ];
  assign fall_irq_m  = mask_q[SEL_FALL_IRQ];
  assign rise_wake_m = mask_q[SEL_RISE_WAKE];
  assign fall_wake_m = mask_q[SEL_FALL_WAKE];

  assert_mask_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == SEL_W'(SEL_RISE_IRQ)) |=> $stable(rise_irq_m));
endmodule

// File: rtl/gpio_sticky_bits.sv
module gpio_sticky_bits #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] set_vec,
  input  logic [NUM_PINS-1:0] clr_vec,
  output logic [NUM_PINS-1:0] sts
);
  // Set takes priority over clear on a per-bit basis.
  always_ff @(posedge clk) begin
    if (rst) begin
      sts <= '0;
    end else begin
      sts <= (sts & ~clr_vec) | set_vec;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (sts == '0));

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (|set_vec) |=> ((sts & $past(set_vec)) == $past(set_vec)));

  assert_w1c_R6: assert property (@(posedge clk) disable iff (rst)
    (|clr_vec) |=> ((sts & $past(clr_vec) & ~$past(set_vec)) == '0));

  assert_untouched_stable_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((sts ^ $past(sts)) & ~($past(set_vec) | $past(clr_vec))) == '0));
endmodule

// File: rtl/gpio_edge_wake.sv
module gpio_edge_wake
  import gpio_ew_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_lvl,
  input  logic                wr_en,
  input  logic [2:0]          wr_addr,
  input  logic [NUM_PINS-1:0] wr_data,
  input  logic [2:0]          rd_addr,
  output logic [NUM_PINS-1:0] rd_data,
  output logic                irq_out,
  output logic                wake_req
);
  logic [NUM_PINS-1:0] rise_evt, fall_evt;
  logic [NUM_PINS-1:0] rise_irq_m, fall_irq_m, rise_wake_m, fall_wake_m;
  logic [NUM_PINS-1:0] irq_hit, wake_hit, clr_vec;
  logic [NUM_PINS-1:0] irq_sts, wake_sts;

  gpio_edge_sense #(.NUM_PINS(NUM_PINS)) u_sense (
    .clk      (clk),
    .rst      (rst),
    .pin_lvl  (pin_lvl),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  gpio_ew_cfg #(.NUM_PINS(NUM_PINS)) u_cfg (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rise_irq_m  (rise_irq_m),
    .fall_irq_m  (fall_irq_m),
    .rise_wake_m (rise_wake_m),
    .fall_wake_m (fall_wake_m)
  );

  assign irq_hit  = (rise_evt & rise_irq_m)  | (fall_evt & fall_irq_m);
  assign wake_hit = (rise_evt & rise_wake_m) | (fall_evt & fall_wake_m);
  assign clr_vec  = (wr_en && wr_addr == SEL_CLEAR) ? wr_data : '0;

  gpio_sticky_bits #(.NUM_PINS(NUM_PINS)) u_irq_sts (
    .clk     (clk),
    .rst     (rst),
    .set_vec (irq_hit),
    .clr_vec (clr_vec),
    .sts     (irq_sts)
  );

  gpio_sticky_bits #(.NUM_PINS(NUM_PINS)) u_wake_sts (
    .clk     (clk),
    .rst     (rst),
    .set_vec (wake_hit),
    .clr_vec (clr_vec),
    .sts     (wake_sts)
  );

  assign irq_out  = |irq_sts;
  assign wake_req = (|wake_hit) | (|wake_sts);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        SEL_RISE_IRQ:  rd_data <= rise_irq_m;
        SEL_FALL_IRQ:  rd_data <= fall_irq_m;
        SEL_RISE_WAKE: rd_data <= rise_wake_m;
        SEL_FALL_WAKE: rd_data <= fall_wake_m;
        SEL_IRQ_STS:   rd_data <= irq_sts;
        SEL_WAKE_STS:  rd_data <= wake_sts;
        default:       rd_data <= '0;
      endcase
    end
  end

  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_out) |-> $past(|irq_hit));

  assert_wake_latch_R9: assert property (@(posedge clk) disable iff (rst)
    (|wake_hit) |=> (wake_sts != '0));

  assert_no_masked_set_R5: assert property (@(posedge clk) disable iff (rst)
    (irq_hit == '0) |=> ((irq_sts & ~$past(irq_sts)) == '0));
endmodule

// File: tb/test_gpio_edge_wake.sv
`timescale 1ns/1ps
module test_gpio_edge_wake;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] pin_lvl = 32'hA5A5_0F0F;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [N-1:0] wr_data = '0;
  logic [2:0]   rd_addr = '0;
  logic [N-1:0] rd_data;
  logic         irq_out, wake_req;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  gpio_edge_wake #(.NUM_PINS(N)) i_gpio_edge_wake (
    .clk(clk), .rst(rst), .pin_lvl(pin_lvl), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_out(irq_out), .wake_req(wake_req)
  );

  task automatic check(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] v);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic drive(input logic [N-1:0] v);
    @(negedge clk);
    pin_lvl = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [N-1:0] v;
    check("R1 irq_out after reset", N'(irq_out), '0);
    check("R1 wake_req after reset", N'(wake_req), '0);
    rd(3'd4, v); check("R1 status zero, no spurious edge", v, '0);
    rd(3'd6, v); check("R1 wake status zero", v, '0);
    for (int a = 0; a < 4; a++) begin
      rd(3'(a), v); check("R1 enable zero", v, '0);
    end
  endtask

  task automatic t_rise;
    logic [N-1:0] v;
    wr(3'd0, (32'h1 << 4) | (32'h1 << 12));
    drive(pin_lvl | (32'h1 << 4));
    check("R8 irq_out rises after rising edge", N'(irq_out), 32'h1);
    rd(3'd4, v); check("R2 rising edge latched", v, 32'h1 << 4);
    drive(pin_lvl & ~(32'h1 << 4));
    rd(3'd4, v); check("R2 falling edge not latched by rising enable", v, 32'h1 << 4);
    wr(3'd5, '1);
    check("R8 irq_out low after clear", N'(irq_out), '0);
  endtask

  task automatic t_fall;
    logic [N-1:0] v;
    wr(3'd1, 32'h1 << 3);
    drive(pin_lvl & ~(32'h1 << 3));
    rd(3'd4, v); check("R3 falling edge latched", v, 32'h1 << 3);
    wr(3'd5, '1);
  endtask

  task automatic t_both;
    logic [N-1:0] v;
    wr(3'd0, (32'h1 << 4) | (32'h1 << 12) | (32'h1 << 20));
    wr(3'd1, (32'h1 << 3) | (32'h1 << 20));
    drive(pin_lvl | (32'h1 << 20));
    rd(3'd4, v); check("R4 both-edge pin rising", v, 32'h1 << 20);
    wr(3'd5, '1);
    drive(pin_lvl & ~(32'h1 << 20));
    rd(3'd4, v); check("R4 both-edge pin falling", v, 32'h1 << 20);
    wr(3'd5, '1);
  endtask

  task automatic t_masked;
    logic [N-1:0] v;
    drive(pin_lvl ^ 32'h1);
    drive(pin_lvl ^ 32'h1);
    check("R5 irq_out stays low", N'(irq_out), '0);
    check("R5 wake_req stays low", N'(wake_req), '0);
    rd(3'd4, v); check("R5 status untouched", v, '0);
    rd(3'd6, v); check("R5 wake status untouched", v, '0);
  endtask

  task automatic t_clear;
    logic [N-1:0] v;
    drive(pin_lvl | (32'h1 << 4) | (32'h1 << 12));
    rd(3'd4, v); check("R6 two bits set", v, (32'h1 << 4) | (32'h1 << 12));
    wr(3'd5, 32'h1 << 4);
    rd(3'd4, v); check("R6 one bit cleared", v, 32'h1 << 12);
    wr(3'd5, '0);
    rd(3'd4, v); check("R6 zero write no effect", v, 32'h1 << 12);
    check("R8 irq_out high with one bit", N'(irq_out), 32'h1);
  endtask

  task automatic t_collide;
    logic [N-1:0] v;
    drive(pin_lvl & ~(32'h1 << 4));
    @(negedge clk);
    pin_lvl = pin_lvl | (32'h1 << 4);
    wr_en = 1'b1; wr_addr = 3'd5; wr_data = (32'h1 << 4) | (32'h1 << 12);
    @(negedge clk);
    wr_en = 1'b0;
    rd(3'd4, v); check("R7 set wins over clear", v, 32'h1 << 4);
    wr(3'd5, '1);
  endtask

  task automatic t_wake;
    logic [N-1:0] v;
    wr(3'd3, 32'h1 << 24);
    check("R10 wake_req idle", N'(wake_req), '0);
    @(negedge clk);
    pin_lvl = pin_lvl & ~(32'h1 << 24);
    #1;
    check("R10 wake_req same cycle as edge", N'(wake_req), 32'h1);
    check("R9 irq_out not raised by wake edge", N'(irq_out), '0);
    @(negedge clk);
    check("R10 wake_req held by latch", N'(wake_req), 32'h1);
    rd(3'd6, v); check("R9 wake status latched", v, 32'h1 << 24);
    rd(3'd4, v); check("R9 interrupt status untouched", v, '0);
    wr(3'd5, 32'h1 << 24);
    check("R6 wake_req low after clear", N'(wake_req), '0);
  endtask

  task automatic t_unmask;
    logic [N-1:0] v;
    drive(pin_lvl & ~(32'h1 << 4));
    drive(pin_lvl | (32'h1 << 4));
    wr(3'd0, '0);
    rd(3'd4, v); check("R11 latched bit kept after disable", v, 32'h1 << 4);
    check("R11 irq_out still high", N'(irq_out), 32'h1);
    wr(3'd5, '1);
    drive(pin_lvl & ~(32'h1 << 4));
    drive(pin_lvl | (32'h1 << 4));
    rd(3'd4, v); check("R11 no new latch after disable", v, '0);
  endtask

  task automatic t_readback;
    logic [N-1:0] v;
    wr(3'd0, 32'h1111_0001);
    wr(3'd1, 32'h2222_0002);
    wr(3'd2, 32'h4444_0004);
    wr(3'd3, 32'h8888_0008);
    rd(3'd0, v); check("R12 read addr 0", v, 32'h1111_0001);
    rd(3'd1, v); check("R12 read addr 1", v, 32'h2222_0002);
    rd(3'd2, v); check("R12 read addr 2", v, 32'h4444_0004);
    rd(3'd3, v); check("R12 read addr 3", v, 32'h8888_0008);
    rd(3'd5, v); check("R12 clear addr reads zero", v, '0);
    rd(3'd7, v); check("R12 unused addr reads zero", v, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_rise();
    t_fall();
    t_both();
    t_masked();
    t_clear();
    t_collide();
    t_wake();
    t_unmask();
    t_readback();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule